// File: doc/BRIEF.md
# Memory-Mapped Device Region Router

This block sits between a core's physical-address path and its small set of memory-mapped devices. For each request it receives an address, an access size and the kind of access (load, store or instruction fetch), and it decides whether the access lands in one of three device windows: a console serial port, a core-local timer/interrupt unit, or a host mailbox. The serial and timer windows are base/size ranges set by parameters. The mailbox is a pair of fixed word addresses with its own rules that depend on the access width.

The decision is registered. One clock after a valid request, the router raises at most one device select. It also presents the address offset inside the chosen window, the forwarded write data and a write strobe, and it returns the read data of the selected device. If the access matches no device, it raises a fault for that one cycle, with a class that depends on the access kind. Separately from routing, it reports whether the address and size would be readable and whether they would be writable as memory-mapped I/O. A debug-mode input closes every window.

Top module: `mmio_router`

## Requirements
- R1: A serial or timer window is hit only when base <= addr and addr + width <= base + size. An access that starts inside a window but runs past its end is not a hit.
- R2: The window bounds are compared with one extra bit of width. A window that ends exactly at the top of the address space therefore accepts accesses up to its last byte and rejects any access that would extend past it.
- R3: Routing priority is fixed: serial first, then timer, then mailbox. Exactly one of `uart_sel`, `timer_sel`, `mbox_sel` is raised, or none.
- R4: A mailbox read matches when addr equals the mailbox address with any legal width of at least 1 byte, or when addr equals the mailbox address + 4 with width exactly 4.
- R5: A mailbox write matches when addr equals the mailbox address or the mailbox address + 4, and only when the width is at most 8 bytes.
- R6: `req_size` encodes the width as 0=1, 1=2, 2=4, 3=8 and 4=16 bytes. Codes 5 to 7 match no window.
- R7: While `dbg_mode` is 1, `rd_ok` and `wr_ok` are 0, no select is raised, and a valid request faults.
- R8: A valid request that selects no device drives `fault` high for exactly one cycle and raises no select. `fault_class` is 1 for a fetch (kind 2), 2 for a load (kind 0, and the reserved kind 3), and 3 for a store (kind 1). It is 0 when there is no fault.
- R9: All outputs are registered one cycle after the request. They are 0 after reset and in any cycle that follows a cycle without `req_valid`.
- R10: `dev_offset` is addr minus the base of the selected window (mailbox base for the mailbox) and is 0 with no select. `dev_wdata` and `dev_we` (1 for kind 1) are forwarded for every valid request. `rsp_rdata` is the read data of the selected device, or 0.
- R11: `rd_ok` reports a read match and `wr_ok` a write match for the request's address and width, whatever its kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_mode | input | 1 | Closes all device windows |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Physical address |
| req_size | input | 3 | Width code (0..4 = 1..16 bytes) |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved (as load) |
| req_wdata | input | DW | Store data |
| uart_rdata | input | DW | Serial port read data |
| timer_rdata | input | DW | Timer unit read data |
| mbox_rdata | input | DW | Mailbox read data |
| uart_sel | output | 1 | Serial port selected |
| timer_sel | output | 1 | Timer unit selected |
| mbox_sel | output | 1 | Mailbox selected |
| dev_offset | output | AW | Offset inside the selected window |
| dev_wdata | output | DW | Forwarded store data |
| dev_we | output | 1 | Request is a store |
| rsp_rdata | output | DW | Read data of the selected device |
| rd_ok | output | 1 | Address/width is I/O readable |
| wr_ok | output | 1 | Address/width is I/O writable |
| fault | output | 1 | Unmapped access, one cycle |
| fault_class | output | 2 | 1 fetch, 2 load, 3 store, 0 none |

## Verification
The assertions check the following on every cycle: at most one select is high, a fault never comes with a select, a fault or a store strobe always follows a request of the matching kind, debug mode leaves nothing open, any window hit lies inside its window by a subtraction-based test, and a high-word mailbox read is always 4 bytes wide. Some behaviour only the bench scenarios can show, because it needs correct expected values from a separate model. This covers the exact boundary bytes of each window, the wrap-free handling of a window ending at the top of a 32-bit space, overlapping windows resolving by priority, the mailbox width rules for loads versus stores, the illegal size codes, and the offset and data returned for each device.

// File: rtl/mmio_router_pkg.sv
// Package mmio_router_pkg
// Shared encodings for the device router: access kinds, fault classes
// and the width-code decode. Assumes widths are powers of two up to 16.
package mmio_router_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_FETCH = 2'd1,
        FLT_LOAD  = 2'd2,
        FLT_STORE = 2'd3
    } fault_class_e;

    localparam int NB_W       = 5;  // byte count 0..16
    localparam int SIZE_CODES = 5;  // legal codes 0..4

    // Byte count of a width code, 0 for an illegal code.
    function automatic logic [NB_W-1:0] size_to_bytes(input logic [2:0] code);
        logic [NB_W-1:0] nb;
        nb = '0;
        if (int'(code) < SIZE_CODES) nb = NB_W'(1) << code;
        return nb;
    endfunction

endpackage

// File: rtl/mmio_region_match.sv
// Module mmio_region_match
// Tests whether an access of nbytes at addr lies wholly in [BASE, BASE+SIZE).
// Assumes nbytes is 0 for an illegal width (never a hit). Both sides of the
// end-bound test carry one extra bit so a window at the top cannot wrap.
module mmio_region_match #(
    parameter int            AW   = 64,
    parameter int            NB_W = 5,
    parameter logic [AW-1:0] BASE = '0,
    parameter logic [AW-1:0] SIZE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [NB_W-1:0] nbytes,
    output logic            hit
);
    localparam logic [AW:0] BASE_X = {1'b0, BASE};
    localparam logic [AW:0] END_X  = {1'b0, BASE} + {1'b0, SIZE};

    logic [AW:0] addr_x;
    logic [AW:0] last_x;

    // Widen the start and compute the exclusive end of the access.
    always_comb begin
        addr_x = {1'b0, addr};
        last_x = addr_x + {{(AW+1-NB_W){1'b0}}, nbytes};
        hit    = (nbytes != '0) && (addr_x >= BASE_X) && (last_x <= END_X);
    end

    // Any hit lies inside the window when measured as a plain offset.
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((addr - BASE) < SIZE));

endmodule

// File: rtl/mmio_mailbox_match.sv
// Module mmio_mailbox_match
// Decodes the two-word host mailbox. Reads match the low word at any legal
// width or the high word at exactly 4 bytes; writes match either word with
// a width of at most 8 bytes. Assumes MBOX_ADDR + 4 does not wrap.
module mmio_mailbox_match #(
    parameter int            AW        = 64,
    parameter int            NB_W      = 5,
    parameter logic [AW-1:0] MBOX_ADDR = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [NB_W-1:0] nbytes,
    output logic            rd_hit,
    output logic            wr_hit
);
    localparam logic [AW-1:0]   HI_ADDR   = MBOX_ADDR + AW'(4);
    localparam logic [NB_W-1:0] WORD_NB   = NB_W'(4);
    localparam logic [NB_W-1:0] WR_MAX_NB = NB_W'(8);

    logic at_lo;
    logic at_hi;

    // Word-address compare and width qualification for each direction.
    always_comb begin
        at_lo  = (addr == MBOX_ADDR);
        at_hi  = (addr == HI_ADDR);
        rd_hit = (nbytes >= NB_W'(1)) && (at_lo || (at_hi && nbytes == WORD_NB));
        wr_hit = (nbytes >= NB_W'(1)) && (nbytes <= WR_MAX_NB) && (at_lo || at_hi);
    end

    // A read that matches away from the low word must be one full word.
    p_hi_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && (addr != MBOX_ADDR)) |-> (nbytes == WORD_NB));

    // A write never matches above 8 bytes.
    p_wr_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |-> (nbytes <= WR_MAX_NB));

endmodule

// File: rtl/mmio_route_sel.sv
// Module mmio_route_sel
// Combines the per-device matches into one routing decision with fixed
// priority (serial, timer, mailbox), the readable/writable flags and the
// fault class. Assumes match inputs are already qualified by width.
module mmio_route_sel
    import mmio_router_pkg::*;
#(
    parameter int NDEV = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_mode,
    input  acc_kind_e         kind,
    input  logic              ser_hit,
    input  logic              tmr_hit,
    input  logic              mb_rd_hit,
    input  logic              mb_wr_hit,
    output logic [NDEV-1:0]   sel,
    output logic              rd_ok,
    output logic              wr_ok,
    output fault_class_e      fclass
);
    localparam int SER = 0;
    localparam int TMR = 1;
    localparam int MBX = 2;

    logic mb_hit;

    // Pick the mailbox rule that fits the access direction.
    always_comb mb_hit = (kind == ACC_STORE) ? mb_wr_hit : mb_rd_hit;

    // Readable and writable reports, closed in debug mode.
    always_comb begin
        rd_ok = !dbg_mode && (ser_hit || tmr_hit || mb_rd_hit);
        wr_ok = !dbg_mode && (ser_hit || tmr_hit || mb_wr_hit);
    end

    // Priority select: serial over timer over mailbox.
    always_comb begin
        sel = '0;
        if (!dbg_mode) begin
            if (ser_hit)      sel[SER] = 1'b1;
            else if (tmr_hit) sel[TMR] = 1'b1;
            else if (mb_hit)  sel[MBX] = 1'b1;
        end
    end

    // Fault class by access kind when nothing is selected.
    always_comb begin
        fclass = FLT_NONE;
        if (sel == '0) begin
            unique case (kind)
                ACC_FETCH: fclass = FLT_FETCH;
                ACC_STORE: fclass = FLT_STORE;
                default:   fclass = FLT_LOAD;
            endcase
        end
    end

    // The serial window always wins when it matches.
    p_ser_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_hit && !dbg_mode) |-> (sel[SER] && $onehot0(sel)));

endmodule

// File: rtl/mmio_router.sv
// Module mmio_router
// Registered router from a physical access to one of three device ports.
// Assumes one request per cycle, no back-pressure, and devices that return
// read data combinationally in the cycle they are selected.
module mmio_router
    import mmio_router_pkg::*;
#(
    parameter int            AW          = 64,
    parameter int            DW          = 64,
    parameter logic [AW-1:0] SERIAL_BASE = 64'h0000_0000_1000_0000,
    parameter logic [AW-1:0] SERIAL_SIZE = 64'h0000_0000_0000_0100,
    parameter logic [AW-1:0] TIMER_BASE  = 64'h0000_0000_0200_0000,
    parameter logic [AW-1:0] TIMER_SIZE  = 64'h0000_0000_000C_0000,
    parameter logic [AW-1:0] MBOX_ADDR   = 64'h0000_0000_8000_1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbg_mode,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_size,
    input  logic [1:0]    req_kind,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] uart_rdata,
    input  logic [DW-1:0] timer_rdata,
    input  logic [DW-1:0] mbox_rdata,
    output logic          uart_sel,
    output logic          timer_sel,
    output logic          mbox_sel,
    output logic [AW-1:0] dev_offset,
    output logic [DW-1:0] dev_wdata,
    output logic          dev_we,
    output logic [DW-1:0] rsp_rdata,
    output logic          rd_ok,
    output logic          wr_ok,
    output logic          fault,
    output logic [1:0]    fault_class
);
    localparam int NDEV = 3;
    localparam int NWIN = 2;
    localparam logic [AW-1:0] WIN_BASE [NWIN] = '{SERIAL_BASE, TIMER_BASE};
    localparam logic [AW-1:0] WIN_SIZE [NWIN] = '{SERIAL_SIZE, TIMER_SIZE};
    localparam logic [AW-1:0] DEV_BASE [NDEV] = '{SERIAL_BASE, TIMER_BASE, MBOX_ADDR};

    logic [NB_W-1:0] nbytes;
    logic [NWIN-1:0] win_hit;
    logic            mb_rd_hit, mb_wr_hit;
    logic [NDEV-1:0] sel_d, sel_q;
    logic            rd_ok_d, wr_ok_d;
    fault_class_e    fclass_d;
    acc_kind_e       kind;
    logic [AW-1:0]   offset_d;

    // Decode the width code and the access kind.
    always_comb begin
        nbytes = size_to_bytes(req_size);
        kind   = acc_kind_e'(req_kind);
    end

    // One range matcher per base/size window.
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        mmio_region_match #(
            .AW(AW), .NB_W(NB_W), .BASE(WIN_BASE[g]), .SIZE(WIN_SIZE[g])
        ) u_match (
            .clk(clk), .rst_n(rst_n), .addr(req_addr), .nbytes(nbytes),
            .hit(win_hit[g])
        );
    end

    mmio_mailbox_match #(
        .AW(AW), .NB_W(NB_W), .MBOX_ADDR(MBOX_ADDR)
    ) u_mbox (
        .clk(clk), .rst_n(rst_n), .addr(req_addr), .nbytes(nbytes),
        .rd_hit(mb_rd_hit), .wr_hit(mb_wr_hit)
    );

    mmio_route_sel #(.NDEV(NDEV)) u_sel (
        .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .kind(kind),
        .ser_hit(win_hit[0]), .tmr_hit(win_hit[1]),
        .mb_rd_hit(mb_rd_hit), .mb_wr_hit(mb_wr_hit),
        .sel(sel_d), .rd_ok(rd_ok_d), .wr_ok(wr_ok_d), .fclass(fclass_d)
    );

    // Offset inside the selected device window.
    always_comb begin
        offset_d = '0;
        for (int i = 0; i < NDEV; i++)
            if (sel_d[i]) offset_d = req_addr - DEV_BASE[i];
    end

    // Register the routing result for one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            sel_q       <= '0;
            dev_offset  <= '0;
            dev_wdata   <= '0;
            dev_we      <= 1'b0;
            rd_ok       <= 1'b0;
            wr_ok       <= 1'b0;
            fault       <= 1'b0;
            fault_class <= FLT_NONE;
        end else begin
            sel_q       <= sel_d;
            dev_offset  <= offset_d;
            dev_wdata   <= req_wdata;
            dev_we      <= (kind == ACC_STORE);
            rd_ok       <= rd_ok_d;
            wr_ok       <= wr_ok_d;
            fault       <= (sel_d == '0);
            fault_class <= fclass_d;
        end
    end

    // Drive the device selects and return the selected read data.
    always_comb begin
        uart_sel  = sel_q[0];
        timer_sel = sel_q[1];
        mbox_sel  = sel_q[2];
        rsp_rdata = '0;
        if (sel_q[0])      rsp_rdata = uart_rdata;
        else if (sel_q[1]) rsp_rdata = timer_rdata;
        else if (sel_q[2]) rsp_rdata = mbox_rdata;
    end

    p_onehot_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({uart_sel, timer_sel, mbox_sel}));

    p_fault_nosel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !(uart_sel || timer_sel || mbox_sel));

    p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($past(req_valid) && $past(rst_n)));

    p_dbg_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(dbg_mode)) |-> (fault && !rd_ok && !wr_ok));

    p_store_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> ($past(req_kind) == ACC_STORE));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !(fault || rd_ok || wr_ok || dev_we));

endmodule

// File: tb/mmio_router_tb.sv
// Bench: behavioural reference model per instance, compared every cycle.
// Instance u_dut uses default (64-bit) windows; u_dut_top is a 32-bit
// variant whose windows overlap and end at the top of the address space.
module mmio_router_tb;

    typedef struct packed {
        logic [2:0]  sel;     // {mbox, timer, uart}
        logic        rd_ok;
        logic        wr_ok;
        logic        fault;
        logic [1:0]  fc;
        logic [63:0] off;
        logic        we;
        logic [63:0] wd;
    } exp_t;

    localparam logic [63:0] RD_UART  = 64'hAAAA_0000_0000_0001;
    localparam logic [63:0] RD_TIMER = 64'hBBBB_0000_0000_0002;
    localparam logic [63:0] RD_MBOX  = 64'hCCCC_0000_0000_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [1:0]  req_kind = '0;
    logic [63:0] req_wdata = '0;
    string       cur_tag = "R9";
    logic        run = 1'b0;
    int          checks = 0;
    int          errors = 0;
    int          nreq = 0;

    always #2 clk = ~clk;

    logic        a_us, a_ts, a_ms, a_we, a_rd, a_wr, a_f;
    logic [63:0] a_off, a_wd, a_rdata;
    logic [1:0]  a_fc;
    logic        b_us, b_ts, b_ms, b_we, b_rd, b_wr, b_f;
    logic [31:0] b_off;
    logic [63:0] b_wd, b_rdata;
    logic [1:0]  b_fc;

    mmio_router u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .req_valid(req_valid),
        .req_addr(req_addr), .req_size(req_size), .req_kind(req_kind),
        .req_wdata(req_wdata), .uart_rdata(RD_UART), .timer_rdata(RD_TIMER),
        .mbox_rdata(RD_MBOX), .uart_sel(a_us), .timer_sel(a_ts), .mbox_sel(a_ms),
        .dev_offset(a_off), .dev_wdata(a_wd), .dev_we(a_we), .rsp_rdata(a_rdata),
        .rd_ok(a_rd), .wr_ok(a_wr), .fault(a_f), .fault_class(a_fc)
    );

    mmio_router #(
        .AW(32), .DW(64),
        .SERIAL_BASE(32'hFFFF_FF00), .SERIAL_SIZE(32'h0000_0100),
        .TIMER_BASE(32'hFFFF_F000),  .TIMER_SIZE(32'h0000_1000),
        .MBOX_ADDR(32'hFFFF_F010)
    ) u_dut_top (
        .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .req_valid(req_valid),
        .req_addr(req_addr[31:0]), .req_size(req_size), .req_kind(req_kind),
        .req_wdata(req_wdata), .uart_rdata(RD_UART), .timer_rdata(RD_TIMER),
        .mbox_rdata(RD_MBOX), .uart_sel(b_us), .timer_sel(b_ts), .mbox_sel(b_ms),
        .dev_offset(b_off), .dev_wdata(b_wd), .dev_we(b_we), .rsp_rdata(b_rdata),
        .rd_ok(b_rd), .wr_ok(b_wr), .fault(b_f), .fault_class(b_fc)
    );

    // Reference model: straight from the requirements, 65-bit arithmetic.
    function automatic exp_t model(input logic v, input logic dbg,
                                   input logic [64:0] a, input logic [2:0] code,
                                   input logic [1:0] kind, input logic [63:0] wd,
                                   input logic [64:0] sb, input logic [64:0] ss,
                                   input logic [64:0] tb, input logic [64:0] ts,
                                   input logic [64:0] mb, input logic [64:0] mask);
        exp_t e;
        logic [64:0] nb;
        logic ser, tmr, mrd, mwr, mhit;
        e = '0;
        nb = (code <= 3'd4) ? (65'd1 << code) : 65'd0;          // R6
        ser = (nb != 0) && (a >= sb) && (a + nb <= sb + ss);       // R1, R2
        tmr = (nb != 0) && (a >= tb) && (a + nb <= tb + ts);
        mrd = (nb >= 1) && ((a == mb) || ((a == mb + 4) && (nb == 4)));           // R4
        mwr = (nb >= 1) && (nb <= 8) && ((a == mb) || (a == mb + 4));             // R5
        if (!v) return e;                                           // R9
        e.rd_ok = !dbg && (ser || tmr || mrd);                      // R11, R7
        e.wr_ok = !dbg && (ser || tmr || mwr);
        e.we = (kind == 2'd1);                                      // R10
        e.wd = wd;
        mhit = (kind == 2'd1) ? mwr : mrd;
        if (!dbg) begin                                             // R3 priority
            if (ser)       begin e.sel = 3'b001; e.off = 64'((a - sb) & mask); end
            else if (tmr)  begin e.sel = 3'b010; e.off = 64'((a - tb) & mask); end
            else if (mhit) begin e.sel = 3'b100; e.off = 64'((a - mb) & mask); end
        end
        if (e.sel == 3'b000) begin                                  // R8
            e.fault = 1'b1;
            e.fc = (kind == 2'd2) ? 2'd1 : (kind == 2'd1) ? 2'd3 : 2'd2;
        end
        return e;
    endfunction

    exp_t  exp_a = '0, exp_b = '0;
    string tag_q = "R9";

    // Advance the model on the same edge that the design registers.
    always @(posedge clk) begin
        tag_q <= cur_tag;
        if (!rst_n) begin
            exp_a <= '0;
            exp_b <= '0;
        end else begin
            exp_a <= model(req_valid, dbg_mode, {1'b0, req_addr}, req_size, req_kind,
                           req_wdata, 65'h1000_0000, 65'h100, 65'h0200_0000,
                           65'h000C_0000, 65'h8000_1000, {1'b0, {64{1'b1}}});
            exp_b <= model(req_valid, dbg_mode, {33'd0, req_addr[31:0]}, req_size, req_kind,
                           req_wdata, 65'hFFFF_FF00, 65'h100, 65'hFFFF_F000,
                           65'h1000, 65'hFFFF_F010, 65'hFFFF_FFFF);
        end
    end

    task automatic chk(input string who, input string fld, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s.%s act=%h exp=%h at %0t", tag_q, who, fld, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] exp_rdata(input logic [2:0] s);
        return s[0] ? RD_UART : s[1] ? RD_TIMER : s[2] ? RD_MBOX : 64'd0;
    endfunction

    // Compare both instances away from the active edge.
    always @(negedge clk) begin
        if (run) begin
            chk("A", "sel",   {61'd0, a_ms, a_ts, a_us}, {61'd0, exp_a.sel});
            chk("A", "rd_ok", {63'd0, a_rd}, {63'd0, exp_a.rd_ok});
            chk("A", "wr_ok", {63'd0, a_wr}, {63'd0, exp_a.wr_ok});
            chk("A", "fault", {61'd0, a_f, a_fc}, {61'd0, exp_a.fault, exp_a.fc});
            chk("A", "off",   a_off, exp_a.off);
            chk("A", "wdata", {a_wd[62:0], a_we}, {exp_a.wd[62:0], exp_a.we});
            chk("A", "rdata", a_rdata, exp_rdata(exp_a.sel));
            chk("B", "sel",   {61'd0, b_ms, b_ts, b_us}, {61'd0, exp_b.sel});
            chk("B", "rd_ok", {63'd0, b_rd}, {63'd0, exp_b.rd_ok});
            chk("B", "wr_ok", {63'd0, b_wr}, {63'd0, exp_b.wr_ok});
            chk("B", "fault", {61'd0, b_f, b_fc}, {61'd0, exp_b.fault, exp_b.fc});
            chk("B", "off",   {32'd0, b_off}, exp_b.off);
            chk("B", "wdata", {b_wd[62:0], b_we}, {exp_b.wd[62:0], exp_b.we});
            chk("B", "rdata", b_rdata, exp_rdata(exp_b.sel));
        end
    end

    task automatic issue(input logic [63:0] a, input logic [2:0] code,
                         input logic [1:0] kind, input string t);
        @(posedge clk);
        #1;
        nreq++;
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = code;
        req_kind  = kind;
        req_wdata = {a[31:0], 32'h5EED_0000 + 32'(nreq)};
        cur_tag   = t;
    endtask

    task automatic idle(input int n, input string t);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            req_valid = 1'b0;
            cur_tag   = t;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R9: reset state, then idle quiet.
        run = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2, "R9");

        // R1: serial and timer window edges (default instance).
        issue(64'h1000_0000, 3'd2, 2'd0, "R1");
        issue(64'h1000_00FC, 3'd2, 2'd0, "R1");
        issue(64'h1000_00FC, 3'd3, 2'd0, "R1");
        issue(64'h0FFF_FFFF, 3'd0, 2'd0, "R1");
        issue(64'h0200_0000, 3'd3, 2'd1, "R1");
        issue(64'h020B_FFF8, 3'd3, 2'd0, "R1");
        issue(64'h020B_FFFC, 3'd3, 2'd0, "R1");

        // R2: windows ending at the top of the 32-bit space.
        issue(64'h0000_0000_FFFF_FFF0, 3'd2, 2'd2, "R2");
        issue(64'h0000_0000_FFFF_FFF8, 3'd3, 2'd2, "R2");
        issue(64'h0000_0000_FFFF_FFF8, 3'd4, 2'd2, "R2");
        issue(64'hFFFF_FFFF_FFFF_FFF8, 3'd3, 2'd0, "R2");
        issue(64'h0000_0000_FFFF_FFFF, 3'd0, 2'd1, "R2");

        // R3: overlapping windows resolve by priority.
        issue(64'h0000_0000_FFFF_FF10, 3'd2, 2'd0, "R3");
        issue(64'h0000_0000_FFFF_F010, 3'd2, 2'd0, "R3");
        issue(64'h0000_0000_FFFF_F010, 3'd3, 2'd1, "R3");
        issue(64'h0000_0000_FFFF_F000, 3'd0, 2'd2, "R3");

        // R4: mailbox read rules.
        issue(64'h8000_1000, 3'd0, 2'd0, "R4");
        issue(64'h8000_1000, 3'd4, 2'd0, "R4");
        issue(64'h8000_1004, 3'd2, 2'd0, "R4");
        issue(64'h8000_1004, 3'd1, 2'd0, "R4");
        issue(64'h8000_1004, 3'd3, 2'd2, "R4");
        issue(64'h8000_1002, 3'd1, 2'd0, "R4");

        // R5: mailbox write rules.
        issue(64'h8000_1000, 3'd3, 2'd1, "R5");
        issue(64'h8000_1004, 3'd0, 2'd1, "R5");
        issue(64'h8000_1004, 3'd3, 2'd1, "R5");
        issue(64'h8000_1000, 3'd4, 2'd1, "R5");
        issue(64'h8000_1008, 3'd2, 2'd1, "R5");

        // R6: illegal width codes never match.
        issue(64'h1000_0000, 3'd5, 2'd0, "R6");
        issue(64'h8000_1000, 3'd7, 2'd1, "R6");
        issue(64'h0200_0010, 3'd6, 2'd2, "R6");

        // R7: debug mode closes every window.
        @(posedge clk);
        #1 dbg_mode = 1'b1;
        issue(64'h1000_0000, 3'd2, 2'd0, "R7");
        issue(64'h8000_1000, 3'd3, 2'd1, "R7");
        issue(64'h0000_0000_FFFF_FF00, 3'd0, 2'd2, "R7");
        idle(1, "R7");
        #1 dbg_mode = 1'b0;

        // R8: fault classes per kind, single-cycle pulse between idles.
        issue(64'h4000_0000, 3'd2, 2'd2, "R8");
        idle(1, "R8");
        issue(64'h4000_0000, 3'd2, 2'd0, "R8");
        issue(64'h4000_0000, 3'd2, 2'd1, "R8");
        issue(64'h4000_0000, 3'd2, 2'd3, "R8");
        idle(2, "R8");

        // R10: offsets, forwarded data and returned read data.
        issue(64'h1000_0044, 3'd1, 2'd1, "R10");
        issue(64'h0200_4000, 3'd3, 2'd0, "R10");
        issue(64'h8000_1004, 3'd2, 2'd0, "R10");
        issue(64'h0000_0000_FFFF_F7F8, 3'd3, 2'd1, "R10");

        // R11: readable/writable independent of kind.
        issue(64'h8000_1004, 3'd1, 2'd1, "R11");
        issue(64'h8000_1004, 3'd3, 2'd0, "R11");
        issue(64'h8000_1000, 3'd4, 2'd2, "R11");
        issue(64'h0200_0000, 3'd2, 2'd3, "R11");

        // R9: back to idle, outputs return to zero.
        idle(3, "R9");
        run = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule